// File: doc/BRIEF.md
# Interrupt-Triggered Single-Transfer Engine

This block lets a peripheral's interrupt request move one data item without CPU work. Software loads a mode word, a source address, a destination address and a transfer count through a small configuration port, then sets the run bit. Each trigger pulse then causes exactly one read from the source address and one write of the returned data to the destination address. These accesses go over a single-beat memory bus with a request/ready handshake. After each round the addresses step according to their mode codes and the count drops by one.

The CPU sees the interrupt only when the count runs out, or after every round when the per-transfer interrupt bit is set. Expiry clears the run bit. Until software sets it again, every trigger is forwarded straight to the CPU interrupt output and causes no bus access. A trigger that arrives while a round is in progress is remembered in a one-deep pending flag and serviced once the block is idle again.

The control state machine has four states. IDLE waits for a trigger. READ holds a read request at the source address. WRITE holds a write request at the destination address. DONE updates the addresses and the count. The transitions are: IDLE to READ on a trigger or pending flag while run is set; READ to WRITE on the read handshake; WRITE to DONE on the write handshake; DONE to IDLE unconditionally. In IDLE, a trigger with run clear stays in IDLE and produces a forwarded CPU interrupt.

Top module: `irq_xfer_engine`

## Requirements
- R1: After reset, mem_req and cpu_irq are low and the run bit is clear.
- R2: Configuration writes select a register by cfg_sel: 0 mode word, 1 source address, 2 destination address, 3 count (low 16 bits). Mode word bits: [1:0] size code, [3:2] source address mode, [5:4] destination address mode, [6] per-transfer interrupt, [7] run. Writes are taken only in IDLE and are ignored while a round is in progress.
- R3: A trigger taken in IDLE with run set raises mem_req in the next cycle as a read (mem_we=0) at the source address. After the read handshake (mem_req and mem_ready high at a clock edge), a write (mem_we=1) follows at the destination address, carrying the read data. mem_req, mem_we and mem_addr hold steady while mem_ready is low.
- R4: Address mode code 10 adds the step to that address after each round. Codes 00, 01 and 11 leave it fixed.
- R5: Size code 00 gives step 1 and mem_size 00. Code 01 gives step 2 and mem_size 01. Code 10 gives step 4 and mem_size 10. Code 11 behaves as 00.
- R6: Each round decrements the count by one. When the count becomes zero, cpu_irq is high for one cycle, two cycles after the write handshake edge.
- R7: With the per-transfer bit set, cpu_irq pulses after every round. With it clear, no cpu_irq is raised for rounds that leave the count nonzero.
- R8: Count expiry clears run. After that, triggers cause no bus request until a mode word with run=1 is written.
- R9: A trigger arriving while a round is in progress is kept pending and starts one further round after the block returns to IDLE. Further triggers during the same round are not counted again.
- R10: A trigger (or pending flag) taken in IDLE with run clear makes cpu_irq high for one cycle, in the cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| trig | input | 1 | Peripheral interrupt request, one cycle per event |
| cpu_irq | output | 1 | Interrupt pulse towards the CPU |
| mem_req | output | 1 | Memory bus request |
| mem_we | output | 1 | Memory bus write (1) or read (0) |
| mem_addr | output | 32 | Memory bus address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Memory bus write data |
| mem_rdata | input | 32 | Memory bus read data |
| mem_ready | input | 1 | Memory bus handshake completion |

## Verification
A corrupted address or count register shows up at mem_addr in the next round, or as a cpu_irq pulse at the wrong round. Checking the ports every cycle against a model therefore exposes it within one transfer. A wrong state sequence or a lost pending flag shows up at once as a mem_req or mem_we that disagrees in the very cycle it happens. A bad run bit appears as a bus request, or a missing forwarded pulse, on the next trigger. Latency on mem_ready is varied between beats, so that the hold of request and address during wait cycles is observed.

// File: rtl/irq_xfer_pkg.sv
package irq_xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } xfer_state_e;

    // Mode word, bit 7 down to bit 0
    typedef struct packed {
        logic       run;
        logic       irq_each;
        logic [1:0] dst_mode;
        logic [1:0] src_mode;
        logic [1:0] size;
    } mode_word_t;

    localparam int MODE_W = $bits(mode_word_t);

    localparam logic [1:0] SEL_MODE = 2'd0;
    localparam logic [1:0] SEL_SRC  = 2'd1;
    localparam logic [1:0] SEL_DST  = 2'd2;
    localparam logic [1:0] SEL_CNT  = 2'd3;

    localparam logic [1:0] AMODE_INC = 2'b10;

    function automatic logic [1:0] size_code(input logic [1:0] raw);
        return (raw == 2'b11) ? 2'b00 : raw;
    endfunction

    function automatic logic [2:0] size_step(input logic [1:0] raw);
        logic [2:0] st;
        unique case (size_code(raw))
            2'b01:   st = 3'd2;
            2'b10:   st = 3'd4;
            default: st = 3'd1;
        endcase
        return st;
    endfunction

endpackage

// File: rtl/xfer_regs.sv
module xfer_regs
    import irq_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              cfg_open,
    input  logic              upd,
    output mode_word_t        mode,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  count,
    output logic              last_round
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [ADDR_W-1:0] step;
    logic              unused_wdata;

    assign step         = ADDR_W'(size_step(mode.size));
    assign last_round   = (count == CNT_ONE);
    assign unused_wdata = ^cfg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode     <= '0;
            src_addr <= '0;
            dst_addr <= '0;
            count    <= '0;
        end else if (upd) begin
            if (mode.src_mode == AMODE_INC) src_addr <= src_addr + step;
            if (mode.dst_mode == AMODE_INC) dst_addr <= dst_addr + step;
            count <= count - CNT_ONE;
            if (last_round) mode.run <= 1'b0;
        end else if (cfg_we && cfg_open) begin
            unique case (cfg_sel)
                SEL_MODE: mode     <= mode_word_t'(cfg_wdata[MODE_W-1:0]);
                SEL_SRC:  src_addr <= cfg_wdata[ADDR_W-1:0];
                SEL_DST:  dst_addr <= cfg_wdata[ADDR_W-1:0];
                SEL_CNT:  count    <= cfg_wdata[CNT_W-1:0];
            endcase
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> count == CNT_W'($past(count) - CNT_ONE)); // R6
    AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        upd && mode.src_mode != AMODE_INC |=> src_addr == $past(src_addr)); // R4
    AST_RUN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        upd && last_round |=> !mode.run); // R8
    AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open && !upd |=> $stable(src_addr) && $stable(dst_addr) && $stable(count)); // R2

endmodule

// File: rtl/xfer_trig.sv
module xfer_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic idle,
    output logic take,
    output logic pend
);

    logic trig_used;

    assign take      = idle && (pend || trig);
    assign trig_used = idle && !pend && trig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= (pend && !take) || (trig && !trig_used);
    end

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !idle |=> pend); // R9
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        trig && !idle |=> pend); // R9

endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
    import irq_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic run,
    input  logic irq_each,
    input  logic last_round,
    input  logic mem_ready,
    output logic idle,
    output logic mem_req,
    output logic mem_we,
    output logic cap,
    output logic upd,
    output logic cpu_irq
);

    xfer_state_e state, state_nx;
    logic        irq_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (take && run) state_nx = ST_READ;
            ST_READ:  if (mem_ready)   state_nx = ST_WRITE;
            ST_WRITE: if (mem_ready)   state_nx = ST_DONE;
            ST_DONE:                   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        idle    = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        cap     = 1'b0;
        upd     = 1'b0;
        irq_nx  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                idle   = 1'b1;
                irq_nx = take && !run;
            end
            ST_READ: begin
                mem_req = 1'b1;
                cap     = mem_ready;
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_DONE: begin
                upd    = 1'b1;
                irq_nx = last_round || irq_each;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cpu_irq <= 1'b0;
        else        cpu_irq <= irq_nx;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_we)); // R3
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ready |=> mem_req && mem_we); // R3
    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        idle && !run |=> !mem_req); // R8

endmodule

// File: rtl/irq_xfer_engine.sv
module irq_xfer_engine
    import irq_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              trig,
    output logic              cpu_irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);

    mode_word_t        mode;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [CNT_W-1:0]  count;
    logic              last_round;
    logic              idle, take, pend, cap, upd;
    logic [DATA_W-1:0] data_q;
    logic              unused_cnt;

    assign unused_cnt = ^count;

    xfer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_open   (idle),
        .upd        (upd),
        .mode       (mode),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr),
        .count      (count),
        .last_round (last_round)
    );

    xfer_trig u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (trig),
        .idle  (idle),
        .take  (take),
        .pend  (pend)
    );

    xfer_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .run        (mode.run),
        .irq_each   (mode.irq_each),
        .last_round (last_round),
        .mem_ready  (mem_ready),
        .idle       (idle),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .cap        (cap),
        .upd        (upd),
        .cpu_irq    (cpu_irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   data_q <= '0;
        else if (cap) data_q <= mem_rdata;
    end

    assign mem_addr  = mem_we ? dst_addr : src_addr;
    assign mem_size  = size_code(mode.size);
    assign mem_wdata = data_q;

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> $stable(mem_addr)); // R3
    AST_QUIET_RESET: assert property (@(posedge clk)
        !rst_n |-> !mem_req && !cpu_irq); // R1

endmodule

// File: tb/irq_xfer_engine_test.sv
module irq_xfer_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        trig = 1'b0;
    logic        cpu_irq, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int lat = 0;
    int wcnt = 0;
    int wr_count = 0;
    int irq_count = 0;
    logic [31:0] last_wr_addr = '0;

    // reference model state
    int          mph = 0;
    bit          mpend = 0, mrun = 0, mev = 0, mirq = 0;
    int          msz = 0, msm = 0, mdm = 0;
    logic [31:0] msrc = '0, mdst = '0, mdata = '0;
    int          mcnt = 0;
    string       mtag = "R7";

    always #2.5 clk = ~clk;

    irq_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .trig(trig), .cpu_irq(cpu_irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    function automatic logic [31:0] rd_fn(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction

    function automatic int step_for(input int sz);
        if (sz == 1) return 2;
        if (sz == 2) return 4;
        return 1;
    endfunction

    function automatic logic [31:0] mw(input bit run, input bit ev, input int dm,
                                       input int sm, input int sz);
        return {24'd0, run, ev, 2'(dm), 2'(sm), 2'(sz)};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // reference model: advances on each rising edge from inputs
    always @(posedge clk) begin
        int  ph;
        bit  tk, tk_trig, np, ni;
        string nt;
        if (!rst_n) begin
            mph = 0; mpend = 0; mrun = 0; mev = 0; mirq = 0;
            msz = 0; msm = 0; mdm = 0; msrc = '0; mdst = '0; mdata = '0;
            mcnt = 0; mtag = "R1";
        end else begin
            ph      = mph;
            tk      = (ph == 0) && (mpend || trig);
            tk_trig = (ph == 0) && !mpend && trig;
            np      = (mpend && !tk) || (trig && !tk_trig);
            ni      = 0;
            nt      = "R7";
            if (ph == 0) begin
                if (tk) begin
                    if (mrun) mph = 1;
                    else begin ni = 1; nt = "R10"; end
                end
                if (cfg_we) begin
                    if (cfg_sel == 0) begin
                        msz = cfg_wdata[1:0]; msm = cfg_wdata[3:2];
                        mdm = cfg_wdata[5:4]; mev = cfg_wdata[6]; mrun = cfg_wdata[7];
                    end else if (cfg_sel == 1) msrc = cfg_wdata;
                    else if (cfg_sel == 2) mdst = cfg_wdata;
                    else mcnt = cfg_wdata[15:0];
                end
            end else if (ph == 1) begin
                if (mem_ready) begin mdata = rd_fn(msrc); mph = 2; end
            end else if (ph == 2) begin
                if (mem_ready) mph = 3;
            end else begin
                if (msm == 2) msrc = msrc + step_for(msz);
                if (mdm == 2) mdst = mdst + step_for(msz);
                mcnt = (mcnt - 1) & 32'hFFFF;
                if (mcnt == 0) begin ni = 1; nt = "R6"; mrun = 0; end
                else if (mev) begin ni = 1; nt = "R7"; end
                mph = 0;
            end
            mpend = np;
            mirq  = ni;
            mtag  = nt;
        end
    end

    // compare, memory responder and monitor, away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                chk(mrun ? "R3" : "R8", "mem_req", 32'(mem_req), 32'(mph == 1 || mph == 2));
                if (mph == 1) begin
                    chk("R4", "read addr", mem_addr, msrc);
                    chk("R3", "mem_we", 32'(mem_we), 32'd0);
                    chk("R5", "mem_size", 32'(mem_size), 32'(msz == 3 ? 0 : msz));
                end
                if (mph == 2) begin
                    chk("R4", "write addr", mem_addr, mdst);
                    chk("R3", "mem_we", 32'(mem_we), 32'd1);
                    chk("R3", "wdata", mem_wdata, mdata);
                end
                chk(mtag, "cpu_irq", 32'(cpu_irq), 32'(mirq));
                if (cpu_irq) irq_count++;
            end
            if (mem_ready) wcnt = 0;
            if (mem_req) begin
                mem_ready = (wcnt >= lat);
                wcnt++;
                mem_rdata = rd_fn(mem_addr);
            end else begin
                mem_ready = 1'b0;
                wcnt = 0;
            end
            if (mem_req && mem_we && mem_ready) begin
                wr_count++;
                last_wr_addr = mem_addr;
                lat = (lat + 1) % 3;
            end
        end
    end

    task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fire();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (mph == 0 && !mpend) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] d, input int n,
                         input logic [31:0] mode);
        cfg_wr(2'd1, s);
        cfg_wr(2'd2, d);
        cfg_wr(2'd3, 32'(n));
        cfg_wr(2'd0, mode);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog: actual hung expected finished");
                summary();
            end
        join_none

        repeat (4) @(negedge clk);
        chk("R1", "mem_req in reset", 32'(mem_req), 32'd0);
        chk("R1", "cpu_irq in reset", 32'(cpu_irq), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: trigger while run is clear is forwarded
        begin
            int ic;
            ic = irq_count;
            fire();
            repeat (3) @(negedge clk);
            chk("R10", "forwarded irq count", 32'(irq_count - ic), 32'd1);
        end

        // byte size, source fixed, destination increments, count 4
        begin
            int ic, wc;
            setup(32'h0000_1000, 32'h0000_2000, 4, mw(1, 0, 2, 0, 0));
            ic = irq_count; wc = wr_count;
            for (int k = 0; k < 3; k++) begin fire(); wait_idle(); end
            chk("R7", "no irq before expiry", 32'(irq_count - ic), 32'd0);
            fire(); wait_idle();
            chk("R6", "irq at expiry", 32'(irq_count - ic), 32'd1);
            chk("R4", "last dst addr", last_wr_addr, 32'h0000_2003);
            wc = wr_count;
            fire(); wait_idle();
            chk("R8", "no transfer after expiry", 32'(wr_count - wc), 32'd0);
        end

        // halfword, both increment, per-transfer interrupt, count 3
        begin
            int ic;
            setup(32'h0000_4000, 32'h0000_5000, 3, mw(1, 1, 2, 2, 1));
            ic = irq_count;
            for (int k = 0; k < 3; k++) begin fire(); wait_idle(); end
            chk("R7", "irq every round", 32'(irq_count - ic), 32'd3);
            chk("R5", "halfword step", last_wr_addr, 32'h0000_5004);
        end

        // word, source code 01 fixed, destination code 11 fixed
        setup(32'h0000_6000, 32'h0000_7000, 2, mw(1, 0, 3, 1, 2));
        fire(); wait_idle(); fire(); wait_idle();
        chk("R4", "fixed dst code 11", last_wr_addr, 32'h0000_7000);

        // size 11 behaves as byte
        setup(32'h0000_8000, 32'h0000_9000, 2, mw(1, 0, 2, 2, 3));
        fire(); wait_idle(); fire(); wait_idle();
        chk("R5", "size 11 step", last_wr_addr, 32'h0000_9001);

        // R9: one pending trigger kept, a second one in the same round not
        begin
            int wc;
            setup(32'h0000_A000, 32'h0000_B000, 5, mw(1, 0, 2, 0, 0));
            wc = wr_count;
            fire(); fire(); fire();
            wait_idle();
            chk("R9", "rounds from three close triggers", 32'(wr_count - wc), 32'd2);
        end

        // R2: destination write during a round is ignored
        setup(32'h0000_C000, 32'h0000_3000, 3, mw(1, 0, 2, 0, 0));
        fire();
        cfg_wr(2'd2, 32'hDEAD_0000);
        wait_idle();
        chk("R2", "write addr round 1", last_wr_addr, 32'h0000_3000);
        fire(); wait_idle();
        chk("R2", "write addr after ignored cfg", last_wr_addr, 32'h0000_3001);

        // R8: rewriting run restores service
        begin
            int wc;
            setup(32'h0000_D000, 32'h0000_E000, 1, mw(1, 0, 2, 2, 0));
            wc = wr_count;
            fire(); wait_idle();
            chk("R8", "service after rearm", 32'(wr_count - wc), 32'd1);
        end

        repeat (4) @(negedge clk);
        summary();
    end

endmodule